// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller around a successive-approximation converter. One of four trigger sources starts a conversion: a software start pulse, either of two timer overflow pulses, or a rising edge on an asynchronous convert-start pin. Trigger sources are accepted only while the block is enabled and idle. The block divides the system clock into a bit-decision clock and drives a trial code to the converter's DAC. On each bit-decision tick it reads a single comparator line and resolves one result bit, starting from the most significant bit.

While a conversion runs, `busy` is high. When `busy` falls, a sticky end-of-conversion flag is set and the result is written into a 16-bit data word in a single clock. The result can be right- or left-justified. In differential mode it is a two's-complement value, and that value is sign-extended when right-justified. The interrupt request is the end-of-conversion flag gated by an enable. Software clears the flag with a clear pulse.

Top module: `sar_conv_seq`

## Requirements
- R1: `trig_sel` chooses the start source: 0 = `sw_start` pulse, 1 = `tmr2_ovf` pulse, 2 = `tmr3_ovf` pulse, 3 = rising edge of `ext_start`. Activity on a source that is not selected starts nothing.
- R2: An accepted trigger, sampled at a clock edge, drives `busy` high from that edge. `busy` then stays high for exactly 12 × (`clk_div` + 1) clock cycles and falls once the last bit is decided.
- R3: The falling edge of `busy` sets `eoc_flag`. `irq` equals `eoc_flag` while `irq_en` is 1 and is 0 while `irq_en` is 0.
- R4: The bit-decision clock ticks once every `clk_div` + 1 system clocks. For example, `clk_div` = 16 gives a conversion of 204 cycles.
- R5: The search tests bits from MSB to LSB. A trial bit is kept when `cmp_ge` is 1 and cleared otherwise. The final code is therefore the largest code not above the comparator's input, saturating at 0x000 and 0xFFF.
- R6: Single-ended mode (`diff_mode` = 0) gives an unsigned result. When `left_just` = 0 it sits in bits [11:0] and bits [15:12] are 0. When `left_just` = 1 it sits in bits [15:4] and bits [3:0] are 0.
- R7: In differential mode (`diff_mode` = 1), `dac_code` is an offset-binary trial level. The result is the final code with its MSB inverted, a two's-complement value from -2048 to +2047. When right-justified, bits [15:12] copy bit 11. When left-justified, bits [3:0] are 0.
- R8: While `en` is 0, every trigger is ignored.
- R9: A trigger that arrives while `busy` is 1 is ignored. It neither restarts nor lengthens the conversion in progress.
- R10: `eoc_flag` is cleared only by an `eoc_clr` pulse. Starting a new conversion leaves it set.
- R11: `data_word` changes only on the clock edge where `busy` falls, and holds its previous value for the whole conversion.
- R12: `ext_start` passes through two synchronizer flops before edge detection. A 0-to-1 change sampled at one clock edge gives `busy` = 1 after the third edge. Holding the pin high does not retrigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| trig_sel | input | 2 | Start-source select |
| sw_start | input | 1 | Software start pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| ext_start | input | 1 | Asynchronous external convert-start pin |
| clk_div | input | 5 | Bit-clock divider minus one |
| left_just | input | 1 | 1 = left-justified data word |
| diff_mode | input | 1 | 1 = differential (signed) result |
| irq_en | input | 1 | Interrupt request enable |
| eoc_clr | input | 1 | Clear pulse for the end-of-conversion flag |
| cmp_ge | input | 1 | Comparator: input is at or above the trial level |
| dac_code | output | 12 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Interrupt request |
| data_word | output | 16 | Formatted conversion result |

## Verification
The bench builds the block with its default parameters: a 12-bit result, a 16-bit data word and a 5-bit divider. Its comparator model compares an integer input level against `dac_code`. Input levels below zero and above full scale are therefore within reach, so both saturation ends are exercised in both coding modes. Most conversions use small divider values so that many of them fit in the run. One directed conversion uses a divider of 16 to confirm the scaling of conversion length, and the external pin is exercised through its synchronizer latency.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      SRC_SOFT  = 2'd0,
      SRC_TMR2  = 2'd1,
      SRC_TMR3  = 2'd2,
      SRC_EXTPIN = 2'd3
   } start_src_e;
endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
   import sar_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       soft_pulse,
   input  logic       t2_pulse,
   input  logic       t3_pulse,
   input  logic       pin_async,
   output logic       trig
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_prev;
   logic                   pin_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= '0;
         pin_prev <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_STAGES-2:0], pin_async};
         pin_prev <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pin_rise = sync_q[SYNC_STAGES-1] & ~pin_prev;

   always_comb begin
      unique case (start_src_e'(sel))
         SRC_SOFT:   trig = soft_pulse;
         SRC_TMR2:   trig = t2_pulse;
         SRC_TMR3:   trig = t3_pulse;
         SRC_EXTPIN: trig = pin_rise;
         default:    trig = 1'b0;
      endcase
   end
endmodule

// File: rtl/sar_bit_clk.sv
module sar_bit_clk #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             cmp_ge,
   output logic [RES_W-1:0] trial,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] final_code
);
   localparam logic [RES_W-1:0] MSB_ONEHOT = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] code_q;
   logic [RES_W-1:0] mask_q;
   logic             busy_q;
   logic [RES_W-1:0] decided;

   assign decided    = cmp_ge ? code_q : (code_q & ~mask_q);
   assign done       = busy_q && tick && mask_q[0];
   assign final_code = decided;
   assign trial      = code_q;
   assign busy       = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         mask_q <= '0;
         busy_q <= 1'b0;
      end else if (start && !busy_q) begin
         code_q <= MSB_ONEHOT;
         mask_q <= MSB_ONEHOT;
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         if (mask_q[0]) begin
            code_q <= decided;
            mask_q <= '0;
            busy_q <= 1'b0;
         end else begin
            code_q <= decided | (mask_q >> 1);
            mask_q <= mask_q >> 1;
         end
      end
   end
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
   parameter int RES_W  = 12,
   parameter int WORD_W = 16
) (
   input  logic [RES_W-1:0]  code,
   input  logic              left_just,
   input  logic              diff_mode,
   output logic [WORD_W-1:0] word
);
   localparam int PAD = WORD_W - RES_W;

   logic [RES_W-1:0] res;
   assign res = diff_mode ? (code ^ {1'b1, {(RES_W-1){1'b0}}}) : code;

   generate
      if (PAD == 0) begin : g_nopad
         assign word = res;
      end else begin : g_pad
         logic ext_bit;
         assign ext_bit = diff_mode & res[RES_W-1];
         assign word = left_just ? {res, {PAD{1'b0}}}
                                 : {{PAD{ext_bit}}, res};
      end
   endgenerate
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
   parameter int RES_W  = 12,
   parameter int WORD_W = 16,
   parameter int DIV_W  = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        trig_sel,
   input  logic              sw_start,
   input  logic              tmr2_ovf,
   input  logic              tmr3_ovf,
   input  logic              ext_start,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              left_just,
   input  logic              diff_mode,
   input  logic              irq_en,
   input  logic              eoc_clr,
   input  logic              cmp_ge,
   output logic [RES_W-1:0]  dac_code,
   output logic              busy,
   output logic              eoc_flag,
   output logic              irq,
   output logic [WORD_W-1:0] data_word
);
   generate
      if (WORD_W < RES_W) begin : g_bad_width
         $error("sar_conv_seq: WORD_W must be at least RES_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sar_conv_seq: SYNC_STAGES must be at least 2");
      end
      if (RES_W < 2) begin : g_bad_res
         $error("sar_conv_seq: RES_W must be at least 2");
      end
   endgenerate

   logic             trig;
   logic             tick;
   logic             done;
   logic [RES_W-1:0] final_code;
   logic [WORD_W-1:0] fmt_word;
   logic             eoc_q;
   logic [WORD_W-1:0] data_q;

   sar_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .sel(trig_sel),
      .soft_pulse(sw_start), .t2_pulse(tmr2_ovf), .t3_pulse(tmr3_ovf),
      .pin_async(ext_start), .trig(trig)
   );

   sar_bit_clk #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(clk_div), .tick(tick)
   );

   sar_search #(.RES_W(RES_W)) u_search (
      .clk(clk), .rst_n(rst_n), .start(trig & en), .tick(tick),
      .cmp_ge(cmp_ge), .trial(dac_code), .busy(busy), .done(done),
      .final_code(final_code)
   );

   sar_fmt #(.RES_W(RES_W), .WORD_W(WORD_W)) u_fmt (
      .code(final_code), .left_just(left_just), .diff_mode(diff_mode),
      .word(fmt_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (done) begin
            eoc_q  <= 1'b1;
            data_q <= fmt_word;
         end else if (eoc_clr) begin
            eoc_q  <= 1'b0;
         end
      end
   end

   assign eoc_flag  = eoc_q;
   assign irq       = eoc_q & irq_en;
   assign data_word = data_q;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              busy,
   input logic              eoc_flag,
   input logic              eoc_clr,
   input logic [WORD_W-1:0] data_word
);
   p_busy_fall_sets_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> eoc_flag);

   p_eoc_rise_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_flag) |-> $fell(busy));

   p_start_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en));

   p_idle_disabled_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !busy) |=> !busy);

   p_eoc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_flag && !eoc_clr) |=> eoc_flag);

   p_data_held_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(data_word));

   p_data_moves_only_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_word) |-> $fell(busy));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .eoc_flag(eoc_flag),
   .eoc_clr(eoc_clr), .data_word(data_word)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  trig_sel = 2'd0;
   logic        sw_start = 1'b0, tmr2_ovf = 1'b0, tmr3_ovf = 1'b0, ext_start = 1'b0;
   logic [4:0]  clk_div = 5'd0;
   logic        left_just = 1'b0, diff_mode = 1'b0, irq_en = 1'b0, eoc_clr = 1'b0;
   logic        cmp_ge;
   logic [11:0] dac_code;
   logic        busy, eoc_flag, irq;
   logic [15:0] data_word;
   int          vin = 0;
   int          n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   always_comb cmp_ge = (vin >= int'({20'd0, dac_code}));

   sar_conv_seq dut (
      .clk(clk), .rst_n(rst_n), .en(en), .trig_sel(trig_sel),
      .sw_start(sw_start), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
      .ext_start(ext_start), .clk_div(clk_div), .left_just(left_just),
      .diff_mode(diff_mode), .irq_en(irq_en), .eoc_clr(eoc_clr),
      .cmp_ge(cmp_ge), .dac_code(dac_code), .busy(busy),
      .eoc_flag(eoc_flag), .irq(irq), .data_word(data_word)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input int v, input logic lj, input logic df);
      int c;
      logic [11:0] r;
      c = (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
      r = df ? (12'(c) ^ 12'h800) : 12'(c);
      if (lj) return {r, 4'h0};
      return df ? {{4{r[11]}}, r} : {4'h0, r};
   endfunction

   task automatic fire(input int src);
      @(negedge clk);
      case (src)
         0: sw_start = 1'b1;
         1: tmr2_ovf = 1'b1;
         2: tmr3_ovf = 1'b1;
         default: ext_start = 1'b1;
      endcase
      @(negedge clk);
      sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
      if (src == 3) repeat (2) @(negedge clk);
   endtask

   // full conversion with checks of busy length, data, flags
   task automatic conv(input int src, input int v, input logic lj, input logic df,
                       input int dv, input logic clr_after, input logic mid_trig);
      logic [15:0] old;
      logic        eoc_before;
      int cyc;
      @(negedge clk);
      trig_sel = 2'(src); vin = v; left_just = lj; diff_mode = df;
      clk_div = 5'(dv); irq_en = $urandom_range(0, 1);
      old = data_word; eoc_before = eoc_flag;
      fire(src);
      check("R1/R2 busy after trigger", busy, 1'b1);
      check("R10 eoc kept at start", eoc_flag, eoc_before);
      cyc = 0;
      while (busy) begin
         cyc++;
         if (data_word !== old) check("R11 data held while busy", data_word, old);
         if (mid_trig && cyc == 5) begin
            sw_start = 1'b1; tmr2_ovf = 1'b1; tmr3_ovf = 1'b1;
         end else begin
            sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
         end
         @(negedge clk);
      end
      sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0;
      check(mid_trig ? "R9 length unchanged by busy trigger" : "R2/R4 busy length",
            cyc, 12 * (dv + 1));
      check(df ? "R5/R7 differential result" : "R5/R6 single-ended result",
            data_word, exp_word(v, lj, df));
      check("R3 eoc set on busy fall", eoc_flag, 1'b1);
      check("R3 irq gating", irq, irq_en);
      if (src == 3) begin
         repeat (4) @(negedge clk);
         check("R12 held pin does not retrigger", busy, 1'b0);
         ext_start = 1'b0;
         repeat (3) @(negedge clk);
      end
      if (clr_after) begin
         eoc_clr = 1'b1;
         @(negedge clk);
         eoc_clr = 1'b0;
         check("R10 eoc cleared by clear pulse", eoc_flag, 1'b0);
         check("R3 irq low after clear", irq, 1'b0);
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset busy", busy, 1'b0);
      check("R3 reset eoc", eoc_flag, 1'b0);
      check("R3 reset irq", irq, 1'b0);
      check("R11 reset data", data_word, 16'h0);

      // R8: disabled, every source ignored
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         fire(s);
         ext_start = 1'b0;
         repeat (3) @(negedge clk);
         check("R8 trigger ignored while disabled", busy, 1'b0);
      end
      check("R8 no eoc while disabled", eoc_flag, 1'b0);
      en = 1'b1;

      // R1: unselected sources ignored
      trig_sel = 2'd1;
      @(negedge clk);
      sw_start = 1'b1; tmr3_ovf = 1'b1; ext_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0; tmr3_ovf = 1'b0;
      repeat (4) @(negedge clk);
      check("R1 unselected sources ignored", busy, 1'b0);
      ext_start = 1'b0;
      repeat (3) @(negedge clk);

      // R12: synchronizer latency
      trig_sel = 2'd3; clk_div = 5'd0; vin = 100;
      @(negedge clk);
      ext_start = 1'b1;
      @(negedge clk); check("R12 no start after 1 edge", busy, 1'b0);
      @(negedge clk); check("R12 no start after 2 edges", busy, 1'b0);
      @(negedge clk); check("R12 start after 3 edges", busy, 1'b1);
      while (busy) @(negedge clk);
      ext_start = 1'b0;
      check("R5 ext result", data_word, exp_word(100, 1'b0, 1'b0));
      eoc_clr = 1'b1; @(negedge clk); eoc_clr = 1'b0;

      // directed corners
      conv(0, 0,     1'b0, 1'b0, 0, 1'b1, 1'b0);
      conv(1, 4095,  1'b0, 1'b0, 1, 1'b1, 1'b0);
      conv(2, 5000,  1'b1, 1'b0, 0, 1'b1, 1'b0);
      conv(0, -7,    1'b1, 1'b0, 0, 1'b1, 1'b0);
      conv(3, 2048,  1'b0, 1'b1, 2, 1'b1, 1'b0);
      conv(0, 2047,  1'b0, 1'b1, 0, 1'b1, 1'b0);
      conv(0, 0,     1'b0, 1'b1, 0, 1'b1, 1'b0);
      conv(1, 9000,  1'b1, 1'b1, 0, 1'b1, 1'b0);
      conv(2, 1024,  1'b1, 1'b1, 1, 1'b1, 1'b0);
      conv(0, 3000,  1'b0, 1'b0, 16, 1'b1, 1'b0);
      conv(0, 1234,  1'b0, 1'b0, 1, 1'b1, 1'b1);
      // R10: eoc survives a new conversion
      conv(0, 77,    1'b0, 1'b0, 0, 1'b0, 1'b0);
      conv(2, 3333,  1'b1, 1'b0, 0, 1'b1, 1'b0);

      // random
      for (int i = 0; i < 40; i++) begin
         conv($urandom_range(0, 3), int'($urandom_range(0, 4400)) - 150,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      finish_run();
   end
endmodule